// File: doc/BRIEF.md
# Partitioned 256-bit SIMD Add/Subtract Unit

This unit executes a small family of vector integer instructions. Each instruction adds or subtracts two 256-bit operand vectors lane by lane. The lane width can be 8, 16, 32, 64 or 128 bits. A carry or borrow travels only inside its own lane. The surrounding pipeline presents a 32-bit instruction word with a valid strobe, together with the two source vectors already read from the register file. One clock later the unit returns the result, a write strobe and the destination register number. When the instruction cannot run, it raises an illegal-instruction flag instead.

The unit decodes its own opcode patterns. A configuration input enables the wide-vector extension; while it is low, every instruction is rejected. The widest mode splits the vector into two independent 128-bit operations. Each of these runs as a 64-bit low part whose carry or borrow feeds a 64-bit high part. Results wrap modulo the lane width, with no saturation and no condition flags.

Top module: `simd_addsub256`

## Requirements
- R1: Instruction bits 4:0 give the destination index, which appears on `dstIdx` together with `resValid` on the clock edge after the valid instruction. Bits 14:5 (the source register numbers) have no effect on the result.
- R2: Opcode bits 31:15 equal to 0111_01000000 followed by 10100, 10101, 10110 or 10111 select lane-wise addition (srcA + srcB) with 8-, 16-, 32- or 64-bit lanes respectively. No carry crosses a lane boundary.
- R3: The same upper 12 bits followed by 11000, 11001, 11010 or 11011 select lane-wise subtraction (srcA − srcB) with 8-, 16-, 32- or 64-bit lanes. No borrow crosses a lane boundary.
- R4: Opcode 0111_01010010_11010 adds and 0111_01010010_11011 subtracts with two 128-bit lanes. Carry or borrow passes from bit 63 to bit 64 and from bit 191 to bit 192, but never from bit 127 to bit 128.
- R5: Every lane wraps modulo 2^width. For example, 8-bit 0xFF + 0x01 gives 0x00 and 0x00 − 0x01 gives 0xFF, and the neighbouring lanes are unaffected.
- R6: With `extEnable` low, a valid instruction (even a legal one) gives `illegal`=1 and `resValid`=0 on the next cycle, and `result` keeps its previous value.
- R7: A valid instruction whose bits 31:15 match none of the ten patterns gives `illegal`=1 and `resValid`=0 on the next cycle, and `result` keeps its previous value.
- R8: A cycle without `instrValid` gives `resValid`=0 and `illegal`=0 on the next cycle, whatever the other inputs are, and `result` keeps its value.
- R9: Synchronous reset (`rst` high at a clock edge) clears `resValid` and `illegal`, even if a valid instruction is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| extEnable | input | 1 | Wide-vector extension enable |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word |
| srcA | input | 256 | First source vector |
| srcB | input | 256 | Second source vector (subtrahend) |
| resValid | output | 1 | Write strobe for the result |
| dstIdx | output | 5 | Destination register index |
| result | output | 256 | Lane-wise sum or difference |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The hardest condition to reach is a carry or borrow that arrives exactly at a lane boundary, because random operands seldom produce a full ripple across a whole lane. The bench therefore pairs all-ones vectors with a pattern that places a 1 in the lowest bit of every lane, and it pairs a zero vector with the same pattern for subtraction. It does this in every lane mode, so every lane must wrap to exactly zero or all ones. For the 128-bit mode, operands that are all ones in bits 63:0 and in bits 191:128 show that the carry crosses bit 64 but not bit 128.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 5;

  // upper 12 opcode bits (instruction bits 31:20)
  localparam logic [11:0] OPC_HI_NARROW = 12'b0111_0100_0000;
  localparam logic [11:0] OPC_HI_WIDE   = 12'b0111_0101_0010;

  typedef enum logic [2:0] {
    LANE8   = 3'd0,
    LANE16  = 3'd1,
    LANE32  = 3'd2,
    LANE64  = 3'd3,
    LANE128 = 3'd4
  } laneSel_e;

  typedef struct packed {
    logic                 writeEn;
    logic                 flagIllegal;
    logic                 doSub;
    laneSel_e             lane;
    logic [REG_IDX_W-1:0] dst;
  } ctrlStrobe_t;

endpackage

// File: rtl/simd_addsub_ctrl.sv
module simd_addsub_ctrl
  import simd_addsub_pkg::*;
(
  input  logic               extEnable,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobe_t        ctl
);

  logic [11:0] opcHi;
  logic [4:0]  opcLo;
  logic        legal;
  logic        doSub;
  laneSel_e    lane;

  assign opcHi = instrWord[31:20];
  assign opcLo = instrWord[19:15];

  always_comb begin
    legal = 1'b0;
    doSub = 1'b0;
    lane  = LANE8;
    if (opcHi == OPC_HI_NARROW) begin
      if (opcLo[4:2] == 3'b101) begin
        legal = 1'b1;
        lane  = laneSel_e'({1'b0, opcLo[1:0]});
      end else if (opcLo[4:2] == 3'b110) begin
        legal = 1'b1;
        doSub = 1'b1;
        lane  = laneSel_e'({1'b0, opcLo[1:0]});
      end
    end else if (opcHi == OPC_HI_WIDE && opcLo[4:1] == 4'b1101) begin
      legal = 1'b1;
      doSub = opcLo[0];
      lane  = LANE128;
    end
  end

  always_comb begin
    ctl.writeEn     = instrValid && legal && extEnable;
    ctl.flagIllegal = instrValid && !(legal && extEnable);
    ctl.doSub       = doSub;
    ctl.lane        = lane;
    ctl.dst         = instrWord[REG_IDX_W-1:0];
  end

endmodule

// File: rtl/simd_addsub_dp.sv
module simd_addsub_dp
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int SEG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          ctl,
  input  logic [DATA_W-1:0]    srcA,
  input  logic [DATA_W-1:0]    srcB,
  output logic                 resValid,
  output logic [REG_IDX_W-1:0] dstIdx,
  output logic [DATA_W-1:0]    result,
  output logic                 illegal
);

  localparam int NUM_SEG   = DATA_W / SEG_W;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);

  logic [SEG_IDX_W-1:0] laneMask;
  logic [NUM_SEG-1:0]   laneStart;
  logic [NUM_SEG-1:0]   carry;
  logic [DATA_W-1:0]    sumNext;

  // a lane starts at every segment whose index is a multiple of the lane size
  always_comb begin
    laneMask = SEG_IDX_W'((1 << ctl.lane) - 1);
    for (int i = 0; i < NUM_SEG; i++) begin
      laneStart[i] = ((SEG_IDX_W'(i) & laneMask) == '0);
    end
  end

  assign carry[0] = 1'b0;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [SEG_W-1:0] aSeg;
    logic [SEG_W-1:0] bSeg;
    logic             cin;
    assign aSeg = srcA[g*SEG_W +: SEG_W];
    assign bSeg = ctl.doSub ? ~srcB[g*SEG_W +: SEG_W] : srcB[g*SEG_W +: SEG_W];
    assign cin  = laneStart[g] ? ctl.doSub : carry[g];
    if (g < NUM_SEG - 1) begin : g_mid
      assign {carry[g+1], sumNext[g*SEG_W +: SEG_W]} =
        {1'b0, aSeg} + {1'b0, bSeg} + {{SEG_W{1'b0}}, cin};
    end else begin : g_last
      assign sumNext[g*SEG_W +: SEG_W] = aSeg + bSeg + {{(SEG_W-1){1'b0}}, cin};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      resValid <= ctl.writeEn;
      illegal  <= ctl.flagIllegal;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.writeEn && !rst) begin
      result <= sumNext;
      dstIdx <= ctl.dst;
    end
  end

endmodule

// File: rtl/simd_addsub256.sv
module simd_addsub256
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int SEG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 extEnable,
  input  logic                 instrValid,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [DATA_W-1:0]    srcA,
  input  logic [DATA_W-1:0]    srcB,
  output logic                 resValid,
  output logic [REG_IDX_W-1:0] dstIdx,
  output logic [DATA_W-1:0]    result,
  output logic                 illegal
);

  ctrlStrobe_t ctl;

  simd_addsub_ctrl u_ctrl (
    .extEnable (extEnable),
    .instrValid(instrValid),
    .instrWord (instrWord),
    .ctl       (ctl)
  );

  simd_addsub_dp #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .srcA    (srcA),
    .srcB    (srcB),
    .resValid(resValid),
    .dstIdx  (dstIdx),
    .result  (result),
    .illegal (illegal)
  );

endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 extEnable,
  input logic                 instrValid,
  input logic [INSTR_W-1:0]   instrWord,
  input logic [DATA_W-1:0]    srcA,
  input logic [DATA_W-1:0]    srcB,
  input logic                 resValid,
  input logic [REG_IDX_W-1:0] dstIdx,
  input logic [DATA_W-1:0]    result,
  input logic                 illegal
);

  localparam logic [16:0] OPC_ADD8 = {OPC_HI_NARROW, 5'b10100};
  localparam logic [16:0] OPC_SUB8 = {OPC_HI_NARROW, 5'b11000};

  // R1: destination index follows the accepted instruction
  p_dst_follows_r1: assert property (@(posedge clk) disable iff (rst)
    resValid |-> dstIdx == $past(instrWord[4:0]));

  // R2: lowest byte of an 8-bit add
  p_byte_add_r2: assert property (@(posedge clk) disable iff (rst)
    (resValid && $past(instrWord[31:15]) == OPC_ADD8)
      |-> result[7:0] == 8'($past(srcA[7:0]) + $past(srcB[7:0])));

  // R3: lowest byte of an 8-bit subtract
  p_byte_sub_r3: assert property (@(posedge clk) disable iff (rst)
    (resValid && $past(instrWord[31:15]) == OPC_SUB8)
      |-> result[7:0] == 8'($past(srcA[7:0]) - $past(srcB[7:0])));

  // R6: disabled extension rejects every valid instruction
  p_disabled_rejects_r6: assert property (@(posedge clk) disable iff (rst)
    (instrValid && !extEnable) |=> (illegal && !resValid));

  // R7: unknown upper opcode bits are flagged
  p_unknown_opcode_r7: assert property (@(posedge clk) disable iff (rst)
    (instrValid && instrWord[31:20] != OPC_HI_NARROW && instrWord[31:20] != OPC_HI_WIDE)
      |=> (illegal && !resValid));

  // R7: write and illegal are never raised together
  p_flag_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(resValid && illegal));

  // R8: idle cycle leaves both outputs low and result untouched
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !instrValid |=> (!resValid && !illegal && $stable(result)));

endmodule

bind simd_addsub256 simd_addsub_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .extEnable (extEnable),
  .instrValid(instrValid),
  .instrWord (instrWord),
  .srcA      (srcA),
  .srcB      (srcB),
  .resValid  (resValid),
  .dstIdx    (dstIdx),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/simd_addsub256_bench.sv
module simd_addsub256_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         extEnable = 1'b1;
  logic         instrValid = 1'b0;
  logic [31:0]  instrWord = '0;
  logic [255:0] srcA = '0;
  logic [255:0] srcB = '0;
  logic         resValid;
  logic [4:0]   dstIdx;
  logic [255:0] result;
  logic         illegal;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  simd_addsub256 u_simd_addsub256 (
    .clk(clk), .rst(rst), .extEnable(extEnable), .instrValid(instrValid),
    .instrWord(instrWord), .srcA(srcA), .srcB(srcB), .resValid(resValid),
    .dstIdx(dstIdx), .result(result), .illegal(illegal)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input bit sub, input int sz, input logic [4:0] dst,
                                          input logic [9:0] srcBits);
    logic [16:0] opc;
    if (sz == 4) opc = {12'b0111_0101_0010, 4'b1101, sub};
    else if (sub) opc = {12'b0111_0100_0000, 3'b110, 2'(sz)};
    else opc = {12'b0111_0100_0000, 3'b101, 2'(sz)};
    return {opc, srcBits[9:5], srcBits[4:0], dst};
  endfunction

  function automatic logic [255:0] refOp(input bit sub, input int sz,
                                         input logic [255:0] a, input logic [255:0] b);
    int w = 8 << sz;
    logic [255:0] mask = {256{1'b1}} >> (256 - w);
    logic [255:0] res = '0;
    for (int k = 0; k < 256 / w; k++) begin
      logic [255:0] la = (a >> (k * w)) & mask;
      logic [255:0] lb = (b >> (k * w)) & mask;
      logic [255:0] r  = sub ? (la - lb) & mask : (la + lb) & mask;
      res |= r << (k * w);
    end
    return res;
  endfunction

  function automatic logic [255:0] laneOnes(input int sz);
    logic [255:0] v = '0;
    for (int k = 0; k < 256; k += (8 << sz)) v[k] = 1'b1;
    return v;
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  // present one instruction, then sample at the following falling edge
  task automatic issue(input logic [31:0] iw, input logic [255:0] a, input logic [255:0] b);
    @(negedge clk);
    instrWord = iw; srcA = a; srcB = b; instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  task automatic runOp(input string req, input bit sub, input int sz,
                       input logic [255:0] a, input logic [255:0] b, input logic [4:0] dst);
    issue(mkInstr(sub, sz, dst, 10'h3A5), a, b);
    check({req, " resValid"}, 256'(resValid), 256'(1));
    check({req, " illegal"}, 256'(illegal), 256'(0));
    check({req, " result"}, result, refOp(sub, sz, a, b));
  endtask

  task automatic testReset();
    check("R9 reset resValid", 256'(resValid), 256'(0));
    check("R9 reset illegal", 256'(illegal), 256'(0));
    @(negedge clk);
    rst = 1'b1; instrValid = 1'b1; instrWord = mkInstr(0, 0, 5'd3, 10'd0);
    @(negedge clk);
    check("R9 reset beats valid", 256'(resValid), 256'(0));
    instrWord = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R9 reset beats illegal", 256'(illegal), 256'(0));
    rst = 1'b0; instrValid = 1'b0;
  endtask

  task automatic testLaneModes();
    for (int sz = 0; sz < 5; sz++) begin
      for (int s = 0; s < 2; s++) begin
        string req = (sz == 4) ? "R4" : (s ? "R3" : "R2");
        runOp({req, " random"}, s[0], sz, rnd256(), rnd256(), 5'(sz * 2 + s));
        runOp({req, " random2"}, s[0], sz, rnd256(), rnd256(), 5'd7);
        if (s == 0) runOp({req, " ones+lane1"}, 1'b0, sz, {256{1'b1}}, laneOnes(sz), 5'd1);
        else        runOp({req, " zero-lane1"}, 1'b1, sz, '0, laneOnes(sz), 5'd2);
        runOp({req, " ones,ones"}, s[0], sz, {256{1'b1}}, {256{1'b1}}, 5'd9);
      end
    end
  endtask

  task automatic testWide();
    logic [255:0] a = {64'd0, {64{1'b1}}, 64'd0, {64{1'b1}}};
    logic [255:0] b = {128'd1, 128'd1};
    issue(mkInstr(0, 4, 5'd4, 10'd0), a, b);
    check("R4 carry bit64/192 only", result, {63'd0, 1'b1, 64'd0, 63'd0, 1'b1, 64'd0});
    issue(mkInstr(1, 4, 5'd4, 10'd0), '0, b);
    check("R4 borrow stays in halves", result, {256{1'b1}});
    issue(mkInstr(0, 4, 5'd4, 10'd0), {128'd0, {128{1'b1}}}, 256'd1);
    check("R4 no carry into bit128", result, 256'd0);
  endtask

  task automatic testWrap();
    issue(mkInstr(0, 0, 5'd5, 10'd0), 256'h34_12_FF, 256'h01_01_01);
    check("R5 byte wrap add", result, 256'h35_13_00);
    issue(mkInstr(1, 0, 5'd5, 10'd0), 256'h34_12_00, 256'h01_01_01);
    check("R5 byte wrap sub", result, 256'h33_11_FF);
    issue(mkInstr(0, 1, 5'd5, 10'd0), 256'h0001_FFFF, 256'h0000_0001);
    check("R5 half wrap add", result, 256'h0001_0000);
  endtask

  task automatic testDst();
    issue(mkInstr(0, 2, 5'd31, 10'h000), 256'd10, 256'd20);
    check("R1 dst 31", 256'(dstIdx), 256'd31);
    check("R1 result", result, 256'd30);
    issue(mkInstr(0, 2, 5'd0, 10'h3FF), 256'd10, 256'd20);
    check("R1 dst 0", 256'(dstIdx), 256'd0);
    check("R1 source bits ignored", result, 256'd30);
  endtask

  task automatic testDisabled();
    logic [255:0] held = result;
    extEnable = 1'b0;
    issue(mkInstr(0, 0, 5'd6, 10'd0), rnd256(), rnd256());
    check("R6 illegal", 256'(illegal), 256'(1));
    check("R6 no write", 256'(resValid), 256'(0));
    check("R6 result held", result, held);
    extEnable = 1'b1;
  endtask

  task automatic testIllegal();
    logic [31:0] bad [3];
    logic [255:0] held = result;
    bad[0] = {12'b0111_0100_0001, 5'b10100, 15'd0};
    bad[1] = {12'b0111_0100_0000, 5'b00000, 15'd0};
    bad[2] = {12'b0111_0101_0010, 5'b10100, 15'd0};
    for (int i = 0; i < 3; i++) begin
      issue(bad[i], rnd256(), rnd256());
      check("R7 illegal", 256'(illegal), 256'(1));
      check("R7 no write", 256'(resValid), 256'(0));
      check("R7 result held", result, held);
    end
  endtask

  task automatic testIdle();
    logic [255:0] held = result;
    @(negedge clk);
    instrValid = 1'b0; instrWord = 32'hFFFF_FFFF; srcA = rnd256(); srcB = rnd256();
    @(negedge clk);
    check("R8 idle resValid", 256'(resValid), 256'(0));
    check("R8 idle illegal", 256'(illegal), 256'(0));
    check("R8 idle result held", result, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testLaneModes();
    testWide();
    testWrap();
    testDst();
    testDisabled();
    testIllegal();
    testIdle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule